// File: doc/BRIEF.md
# Region Miss Order Buffer

This block keeps a circular history of trigger accesses for a spatial-memory prefetcher. A trigger record holds three things: the number of the region it touched, a pattern-table key, and a delta. The key is the program counter placed above the region byte-offset bits, with the trigger's line offset added in. The delta counts the non-trigger accesses seen since the previous trigger. Each record is written at the head pointer, and the head then moves forward one slot. The head therefore always names either the first free slot or, once every slot is valid, the oldest record.

When an access reports a demand cache miss, the block searches backward from the newest record, one slot per cycle. It looks for the most recent record of the missed region. The search ends with a one-cycle done pulse that carries a found flag and the matching slot index, which downstream reconstruction logic can use. A combinational read port and the head value let that logic walk the records forward from the reported index.

Writes and lookups both use valid/ready. A transfer happens on a clock edge where valid and ready are both high. Both ready signals are low while a search runs. A producer must hold valid and its data steady until the transfer happens. A write and a lookup in the same cycle are both taken, and the write lands first.

Top module: `region_miss_order_buf`

## Requirements
- R1: After reset the head is 0, every slot reads as invalid, and `wr_ready` and `lk_ready` are both high.
- R2: An accepted write stores the region, the key and the delta into the slot at the head and marks that slot valid. The head then becomes (head+1) modulo DEPTH, and older slots are left unchanged.
- R3: The stored key equals (`wr_pc` << SR_BITS) + `wr_offset`.
- R4: A lookup accepted with `lk_miss` low starts no search. No done pulse follows, and the records and the head do not change.
- R5: A search with `lk_miss` high examines slots from head-1 toward older slots. It reports found=1 and the index of the most recent valid slot whose region equals `lk_region`.
- R6: A search that reaches an invalid slot before any match ends with found=0.
- R7: A search whose next slot would be the head ends with found=0. When the buffer is full, the slot at the head (the oldest record) is therefore never examined.
- R8: A search examines one slot per clock. `srch_done` rises n clock edges after the accepting edge, where n is the number of slots examined, and it stays high for exactly one cycle.
- R9: While a search runs, `wr_ready` and `lk_ready` are low and the head does not move. A write held during the search completes on the edge after `srch_done`.
- R10: When a write and a miss lookup are accepted on the same edge, the search includes the new record as the newest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write may be accepted |
| wr_region | input | REGION_W | Region number of the trigger |
| wr_pc | input | PC_W | Program counter of the trigger |
| wr_offset | input | OFF_W | Line offset of the trigger within its region |
| wr_delta | input | DELTA_W | Non-trigger accesses since the previous trigger |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup may be accepted |
| lk_miss | input | 1 | The looked-up access missed in the cache |
| lk_region | input | REGION_W | Region number to search for |
| srch_done | output | 1 | One-cycle pulse at the end of a search |
| srch_found | output | 1 | A match was found (qualified by srch_done) |
| srch_idx | output | IDX_W | Slot index of the match (qualified by srch_done and srch_found) |
| head | output | IDX_W | Current head pointer |
| rd_idx | input | IDX_W | Slot selected on the read port |
| rd_valid | output | 1 | Valid bit of the selected slot |
| rd_region | output | REGION_W | Region of the selected slot |
| rd_key | output | PC_W+SR_BITS | Pattern key of the selected slot |
| rd_delta | output | DELTA_W | Delta of the selected slot |

## Verification
The assertions check several rules on every cycle:
- reset leaves the head at zero with no valid slot;
- the head steps by exactly one, with wrap, on each write and otherwise holds;
- the head is frozen while a search runs;
- an examined slot that is invalid or matching ends the search on the next edge with the matching found value and index;
- done never lasts two cycles.

Only the bench scenarios can show the rest: which record is the most recent match over many write histories that wrap the buffer, that the oldest record in a full buffer is skipped, the exact latency of each search, the stored key arithmetic, that a non-miss lookup has no effect, and the ordering of writes that are held or arrive in the same cycle as a lookup.

// File: rtl/rmob_pkg.sv
package rmob_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } rmob_state_e;

  function automatic int unsigned wrap_dec(int unsigned i, int unsigned depth);
    return (i == 0) ? depth - 1 : i - 1;
  endfunction

  function automatic int unsigned wrap_inc(int unsigned i, int unsigned depth);
    return (i == depth - 1) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/rmob_keygen.sv
module rmob_keygen #(
  parameter int PC_W    = 8,
  parameter int SR_BITS = 6,
  parameter int OFF_W   = 3,
  localparam int KEY_W  = PC_W + SR_BITS
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] line_off,
  output logic [KEY_W-1:0] key
);

  // Line offset is narrower than the region byte offset, so the sum never carries into the PC bits.
  always_comb begin
    key = {pc, {SR_BITS{1'b0}}} + KEY_W'(line_off);
  end

  initial begin
    a_r3_offset_fits: assert (OFF_W <= SR_BITS);
  end

endmodule

// File: rtl/rmob_store.sv
module rmob_store #(
  parameter int DEPTH    = 8,
  parameter int REGION_W = 8,
  parameter int KEY_W    = 14,
  parameter int DELTA_W  = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [REGION_W-1:0] w_region,
  input  logic [KEY_W-1:0]    w_key,
  input  logic [DELTA_W-1:0]  w_delta,
  output logic [IDX_W-1:0]    head_o,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [REGION_W-1:0] rd_region,
  output logic [KEY_W-1:0]    rd_key,
  output logic [DELTA_W-1:0]  rd_delta,
  input  logic [IDX_W-1:0]    pr_idx,
  output logic                pr_valid,
  output logic [REGION_W-1:0] pr_region
);
  import rmob_pkg::*;

  logic [IDX_W-1:0]    head_q;
  logic [DEPTH-1:0]    val_w;
  logic [REGION_W-1:0] reg_w [DEPTH];
  logic [KEY_W-1:0]    key_w [DEPTH];
  logic [DELTA_W-1:0]  del_w [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)     head_q <= '0;
    else if (we) head_q <= IDX_W'(wrap_inc(int'(head_q), DEPTH));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic                v_q;
    logic [REGION_W-1:0] r_q;
    logic [KEY_W-1:0]    k_q;
    logic [DELTA_W-1:0]  d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        r_q <= '0;
        k_q <= '0;
        d_q <= '0;
      end else if (we && head_q == IDX_W'(g)) begin
        v_q <= 1'b1;
        r_q <= w_region;
        k_q <= w_key;
        d_q <= w_delta;
      end
    end
    assign val_w[g] = v_q;
    assign reg_w[g] = r_q;
    assign key_w[g] = k_q;
    assign del_w[g] = d_q;
  end

  assign head_o    = head_q;
  assign rd_valid  = val_w[rd_idx];
  assign rd_region = reg_w[rd_idx];
  assign rd_key    = key_w[rd_idx];
  assign rd_delta  = del_w[rd_idx];
  assign pr_valid  = val_w[pr_idx];
  assign pr_region = reg_w[pr_idx];

  // R1: the first cycle out of reset shows an empty buffer
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (head_q == '0 && val_w == '0));

  // R2: head steps by one with wrap on a write
  a_r2_head_step: assert property (@(posedge clk) disable iff (rst)
    we |=> (head_q == (($past(head_q) == IDX_W'(DEPTH-1)) ? '0 : $past(head_q) + 1'b1)));

  // R2: head holds without a write
  a_r2_head_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(head_q));

endmodule

// File: rtl/rmob_search.sv
module rmob_search #(
  parameter int DEPTH    = 8,
  parameter int REGION_W = 8,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [IDX_W-1:0]    start_ptr,
  input  logic [REGION_W-1:0] target,
  input  logic [IDX_W-1:0]    stop_at,
  output logic [IDX_W-1:0]    pr_idx,
  input  logic                pr_valid,
  input  logic [REGION_W-1:0] pr_region,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  import rmob_pkg::*;

  rmob_state_e         state_q;
  logic [IDX_W-1:0]    ptr_q;
  logic [IDX_W-1:0]    ptr_prev;
  logic [REGION_W-1:0] tgt_q;
  logic                done_q;
  logic                found_q;
  logic [IDX_W-1:0]    idx_q;

  assign ptr_prev = IDX_W'(wrap_dec(int'(ptr_q), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            ptr_q   <= start_ptr;
            tgt_q   <= target;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (!pr_valid) begin
            done_q  <= 1'b1;
            found_q <= 1'b0;
            state_q <= S_IDLE;
          end else if (pr_region == tgt_q) begin
            done_q  <= 1'b1;
            found_q <= 1'b1;
            idx_q   <= ptr_q;
            state_q <= S_IDLE;
          end else if (ptr_prev == stop_at) begin
            done_q  <= 1'b1;
            found_q <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            ptr_q <= ptr_prev;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pr_idx = ptr_q;
  assign busy   = (state_q == S_SCAN);
  assign done   = done_q;
  assign found  = found_q;
  assign idx    = idx_q;

  // R5: a valid matching slot under examination is reported on the next edge
  a_r5_match_reported: assert property (@(posedge clk) disable iff (rst)
    (busy && pr_valid && pr_region == tgt_q) |=> (done && found && idx == $past(ptr_q)));

  // R6: an invalid slot ends the search without a match
  a_r6_invalid_stops: assert property (@(posedge clk) disable iff (rst)
    (busy && !pr_valid) |=> (done && !found));

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/region_miss_order_buf.sv
module region_miss_order_buf #(
  parameter int DEPTH    = 8,
  parameter int REGION_W = 8,
  parameter int PC_W     = 8,
  parameter int SR_BITS  = 6,
  parameter int OFF_W    = 3,
  parameter int DELTA_W  = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int KEY_W   = PC_W + SR_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [PC_W-1:0]     wr_pc,
  input  logic [OFF_W-1:0]    wr_offset,
  input  logic [DELTA_W-1:0]  wr_delta,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic                lk_miss,
  input  logic [REGION_W-1:0] lk_region,
  output logic                srch_done,
  output logic                srch_found,
  output logic [IDX_W-1:0]    srch_idx,
  output logic [IDX_W-1:0]    head,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [REGION_W-1:0] rd_region,
  output logic [KEY_W-1:0]    rd_key,
  output logic [DELTA_W-1:0]  rd_delta
);
  import rmob_pkg::*;

  logic                wr_fire;
  logic                lk_start;
  logic                busy;
  logic [KEY_W-1:0]    key;
  logic [IDX_W-1:0]    head_w;
  logic [IDX_W-1:0]    newest;
  logic [IDX_W-1:0]    pr_idx;
  logic                pr_valid;
  logic [REGION_W-1:0] pr_region;

  assign wr_ready = !busy;
  assign lk_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign lk_start = lk_valid && lk_ready && lk_miss;
  // A write on the same edge becomes the newest slot, which is the current head.
  assign newest   = wr_fire ? head_w : IDX_W'(wrap_dec(int'(head_w), DEPTH));
  assign head     = head_w;

  rmob_keygen #(.PC_W(PC_W), .SR_BITS(SR_BITS), .OFF_W(OFF_W)) u_key (
    .pc(wr_pc), .line_off(wr_offset), .key(key)
  );

  rmob_store #(.DEPTH(DEPTH), .REGION_W(REGION_W), .KEY_W(KEY_W), .DELTA_W(DELTA_W)) u_store (
    .clk(clk), .rst(rst), .we(wr_fire),
    .w_region(wr_region), .w_key(key), .w_delta(wr_delta),
    .head_o(head_w),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_region(rd_region),
    .rd_key(rd_key), .rd_delta(rd_delta),
    .pr_idx(pr_idx), .pr_valid(pr_valid), .pr_region(pr_region)
  );

  rmob_search #(.DEPTH(DEPTH), .REGION_W(REGION_W)) u_search (
    .clk(clk), .rst(rst), .start(lk_start), .start_ptr(newest),
    .target(lk_region), .stop_at(head_w),
    .pr_idx(pr_idx), .pr_valid(pr_valid), .pr_region(pr_region),
    .busy(busy), .done(srch_done), .found(srch_found), .idx(srch_idx)
  );

  // R9: head frozen while a search is in flight
  a_r9_head_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(head_w));

  // R4: a non-miss lookup from idle leaves the block idle
  a_r4_no_search: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready && !lk_miss) |=> !busy);

  initial begin
    a_r7_depth_min: assert (DEPTH >= 2);
  end

endmodule

// File: tb/tb_region_miss_order_buf.sv
module tb_region_miss_order_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int REGION_W = 8;
  localparam int PC_W = 8;
  localparam int SR_BITS = 6;
  localparam int OFF_W = 3;
  localparam int DELTA_W = 4;
  localparam int IDX_W = 3;
  localparam int KEY_W = PC_W + SR_BITS;

  logic clk = 0;
  logic rst = 1;
  logic wr_valid = 0, lk_valid = 0, lk_miss = 0;
  logic wr_ready, lk_ready;
  logic [REGION_W-1:0] wr_region = 0, lk_region = 0;
  logic [PC_W-1:0] wr_pc = 0;
  logic [OFF_W-1:0] wr_offset = 0;
  logic [DELTA_W-1:0] wr_delta = 0;
  logic srch_done, srch_found;
  logic [IDX_W-1:0] srch_idx, head;
  logic [IDX_W-1:0] rd_idx = 0;
  logic rd_valid;
  logic [REGION_W-1:0] rd_region;
  logic [KEY_W-1:0] rd_key;
  logic [DELTA_W-1:0] rd_delta;

  int checks = 0;
  int fails = 0;

  int m_reg [DEPTH];
  int m_key [DEPTH];
  int m_del [DEPTH];
  bit m_val [DEPTH];
  int m_head = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_miss_order_buf #(.DEPTH(DEPTH), .REGION_W(REGION_W), .PC_W(PC_W),
    .SR_BITS(SR_BITS), .OFF_W(OFF_W), .DELTA_W(DELTA_W)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_region(wr_region), .wr_pc(wr_pc), .wr_offset(wr_offset), .wr_delta(wr_delta),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_miss(lk_miss), .lk_region(lk_region),
    .srch_done(srch_done), .srch_found(srch_found), .srch_idx(srch_idx), .head(head),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_region(rd_region), .rd_key(rd_key),
    .rd_delta(rd_delta)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dec(int i);
    return (i == 0) ? DEPTH - 1 : i - 1;
  endfunction

  function automatic void model_write(int r, int pc, int off, int d);
    m_reg[m_head] = r;
    m_key[m_head] = (pc << SR_BITS) + off;
    m_del[m_head] = d;
    m_val[m_head] = 1;
    m_head = (m_head + 1) % DEPTH;
  endfunction

  // reason: 5 found, 6 invalid stop, 7 wrapped to head
  function automatic void model_search(int r, output bit f, output int ix,
                                       output int lat, output int why);
    int p = dec(m_head);
    int n = 0;
    f = 0; ix = 0; why = 7;
    forever begin
      n++;
      if (!m_val[p]) begin why = 6; break; end
      if (m_reg[p] == r) begin f = 1; ix = p; why = 5; break; end
      if (dec(p) == m_head) begin why = 7; break; end
      p = dec(p);
    end
    lat = n;
  endfunction

  task automatic check_store();
    for (int s = 0; s < DEPTH; s++) begin
      @(negedge clk);
      rd_idx = IDX_W'(s);
      #1;
      check(rd_valid == m_val[s], "R2 slot valid", int'(rd_valid), int'(m_val[s]));
      if (m_val[s]) begin
        check(int'(rd_region) == m_reg[s], "R2 slot region", int'(rd_region), m_reg[s]);
        check(int'(rd_key) == m_key[s], "R3 slot key", int'(rd_key), m_key[s]);
        check(int'(rd_delta) == m_del[s], "R2 slot delta", int'(rd_delta), m_del[s]);
      end
    end
    check(int'(head) == m_head, "R2 head", int'(head), m_head);
  endtask

  task automatic do_write(int r, int pc, int off, int d);
    @(negedge clk);
    wr_valid = 1; wr_region = REGION_W'(r); wr_pc = PC_W'(pc);
    wr_offset = OFF_W'(off); wr_delta = DELTA_W'(d);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
    model_write(r, pc, off, d);
  endtask

  // Wait for done after the accepting edge; returns latency in edges
  task automatic wait_done(output int lat);
    lat = -1;
    for (int k = 1; k <= 2 * DEPTH; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (srch_done) begin lat = k; break; end
    end
  endtask

  task automatic check_result(int lat, bit ef, int eix, int elat, int why);
    string tag;
    tag = (why == 5) ? "R5" : (why == 6) ? "R6" : "R7";
    check(lat == elat, "R8 latency", lat, elat);
    check(srch_found == ef, {tag, " found"}, int'(srch_found), int'(ef));
    if (ef) check(int'(srch_idx) == eix, {tag, " index"}, int'(srch_idx), eix);
    @(negedge clk);
    check(srch_done == 0, "R8 single-cycle done", int'(srch_done), 0);
  endtask

  task automatic do_lookup(int r);
    bit ef; int eix, elat, why, lat;
    model_search(r, ef, eix, elat, why);
    @(negedge clk);
    lk_valid = 1; lk_miss = 1; lk_region = REGION_W'(r);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    // the negedge just passed is before the first examining edge
    lat = -1;
    if (srch_done) lat = 0;
    else begin
      for (int k = 1; k <= 2 * DEPTH; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (srch_done) begin lat = k; break; end
      end
    end
    check_result(lat, ef, eix, elat, why);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < DEPTH; s++) m_val[s] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(head == 0, "R1 head", int'(head), 0);
    check(wr_ready && lk_ready, "R1 ready", int'(wr_ready && lk_ready), 1);
    check_store();

    // R6 empty buffer search
    do_lookup(5);

    // Fill with distinct regions; R7 oldest slot skipped when full
    for (int i = 0; i < DEPTH; i++) do_write(100 + i, 30 + i, i, i);
    check_store();
    for (int r = 99; r <= 100 + DEPTH; r++) do_lookup(r);

    // R4 non-miss lookup is ignored
    begin
      bit seen = 0;
      @(negedge clk);
      lk_valid = 1; lk_miss = 0; lk_region = 8'd103;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (srch_done) seen = 1;
      end
      check(!seen, "R4 no done", int'(seen), 0);
      check(wr_ready, "R4 still idle", int'(wr_ready), 1);
      check_store();
    end

    // Sweep: repeated regions, many wraps (R2, R3, R5, R6, R7, R8)
    for (int i = 0; i < 3 * DEPTH; i++) begin
      do_write((i * 3) % 5 + 1, (i * 37) % 256, i % 8, i % 16);
      check_store();
      for (int r = 0; r <= 6; r++) do_lookup(r);
      do_lookup(100 + (i % DEPTH));
    end

    // R9 write held off during a search, lands after done
    begin
      bit ef; int eix, elat, why, lat;
      model_search(250, ef, eix, elat, why);
      @(negedge clk);
      lk_valid = 1; lk_miss = 1; lk_region = 8'd250;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 0;
      wr_valid = 1; wr_region = 8'd77; wr_pc = 8'd200; wr_offset = 3'd5; wr_delta = 4'd9;
      #1;
      check(!wr_ready && !lk_ready, "R9 ready low while busy", int'(wr_ready), 0);
      lat = -1;
      for (int k = 1; k <= 2 * DEPTH; k++) begin
        @(posedge clk);
        @(negedge clk);
        check(int'(head) == m_head, "R9 head frozen", int'(head), m_head);
        if (srch_done) begin lat = k; break; end
      end
      check(lat == elat, "R9 latency", lat, elat);
      check(srch_found == ef, "R9 found", int'(srch_found), int'(ef));
      @(posedge clk);
      @(negedge clk);
      wr_valid = 0;
      model_write(77, 200, 5, 9);
      check_store();
    end

    // R10 simultaneous write and lookup of the written region
    begin
      int lat, oh;
      oh = m_head;
      @(negedge clk);
      wr_valid = 1; wr_region = 8'd222; wr_pc = 8'd17; wr_offset = 3'd7; wr_delta = 4'd15;
      lk_valid = 1; lk_miss = 1; lk_region = 8'd222;
      @(posedge clk);
      @(negedge clk);
      wr_valid = 0; lk_valid = 0;
      model_write(222, 17, 7, 15);
      wait_done(lat);
      check(lat == 1, "R10 latency", lat, 1);
      check(srch_found == 1, "R10 found", int'(srch_found), 1);
      check(int'(srch_idx) == oh, "R10 index", int'(srch_idx), oh);
      check_store();
    end

    // R1 reset again clears state
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int s = 0; s < DEPTH; s++) m_val[s] = 0;
    m_head = 0;
    check_store();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule